// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a serial chain of boundary cells placed between a chip's pins and its core logic. Every cell has two storage stages: a capture stage that either loads a parallel value or takes part in a serial shift, and an update stage that is loaded from the capture stage on command and holds a test value for the cell's parallel output. An output multiplexer in each cell chooses between the live functional value and the held test value, according to a mode input.

The chain has two groups of cells. Input cells sit between the input pins and the core. Output cells sit between the core and the output pins. The strobes come from a TAP controller: a shift/capture select, a data-register clock enable, an update enable and a mode code. The chain is clocked by a single clock, and the two enables are sampled on its rising edge. The serial input is fed from the test data input, and the serial output goes toward the test data output.

The mode code selects the test setup. In functional mode the chip runs normally while the chain can still sample pins. In external-test mode the output pins are driven from the update stages so that the board wiring can be tested. In internal-test mode the core inputs come from the update stages, which isolates the core from its pins. In clamp mode the output pins are held from the update stages while the core inputs stay functional.

Top module: `edge_scan_chain`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every capture stage and every update stage to 0.
- R2: With `captureEn`=1 and `shiftSel`=0 at an edge, each input cell k (chain position k, 0 ≤ k < NUM_IN) loads `pinIn[k]`, and each output cell j (chain position NUM_IN+j) loads `coreOut[j]` into its capture stage.
- R3: With `captureEn`=1 and `shiftSel`=1 at an edge, chain position 0 loads `scanIn` and position p loads the old value of position p-1. `scanOut` always shows the capture stage at position NUM_IN+NUM_OUT-1.
- R4: With `updateEn`=1 at an edge, every update stage takes the value of its own capture stage.
- R5: The update stages, and with them every test-driven output, keep their values while the chain shifts or captures without `updateEn`.
- R6: With `mode`=2'b00 (functional), `coreIn` equals `pinIn` and `pinOut` equals `coreOut` in the same cycle.
- R7: With `mode`=2'b01 (external test), `pinOut[j]` is driven by the update stage at chain position NUM_IN+j, and `coreIn` equals `pinIn`.
- R8: With `mode`=2'b10 (internal test), `coreIn[k]` is driven by the update stage at chain position k, and `pinOut` equals `coreOut`.
- R9: With `mode`=2'b11 (clamp), `pinOut` is driven from the update stages as in R7, and `coreIn` equals `pinIn`.
- R10: With `captureEn`=0, the capture stages do not change, whatever the value of `shiftSel`.
- R11: When capture or shift coincides with `updateEn` at the same edge, the update stages receive the capture values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain clock |
| rst | input | 1 | Synchronous reset, active high |
| shiftSel | input | 1 | 1 = shift the chain, 0 = parallel capture (qualified by captureEn) |
| captureEn | input | 1 | Data-register clock enable |
| updateEn | input | 1 | Update-stage load enable |
| mode | input | 2 | 00 functional, 01 external test, 10 internal test, 11 clamp |
| scanIn | input | 1 | Serial data into chain position 0 |
| scanOut | output | 1 | Serial data from the last chain position |
| pinIn | input | NUM_IN | Values arriving at the input pins |
| coreIn | output | NUM_IN | Values presented to the core inputs |
| coreOut | input | NUM_OUT | Values produced by the core for the output pins |
| pinOut | output | NUM_OUT | Values driven toward the output pins |

## Verification
The hardest case is an update that lands at the same edge as a capture or a shift. The update stage has to take the old capture contents and not the new ones, and this case only arises when two strobes coincide, which a real TAP controller never does. The stimulus forces these overlaps directly, and it also runs long random mixes of shift, capture, update and mode changes while the pins and core values keep moving. A behavioural reference model follows every edge. It checks that outputs driven by test data stay fixed through whole shift sequences, and that they change only at an update.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC  = 2'b00,
    MODE_EXT   = 2'b01,
    MODE_INT   = 2'b10,
    MODE_CLAMP = 2'b11
  } scan_mode_e;

  typedef struct packed {
    logic doShift;
    logic doCapture;
    logic doUpdate;
    logic coreFromUpd;
    logic pinFromUpd;
  } scan_strobe_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell
  import scan_chain_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  scan_strobe_t strobe,
  input  logic         useUpd,
  input  logic         serIn,
  output logic         serOut,
  input  logic         parIn,
  output logic         parOut
);

  logic capQ;
  logic updQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      capQ <= 1'b0;
    end else if (strobe.doShift) begin
      capQ <= serIn;
    end else if (strobe.doCapture) begin
      capQ <= parIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      updQ <= 1'b0;
    end else if (strobe.doUpdate) begin
      updQ <= capQ;
    end
  end

  assign serOut = capQ;
  assign parOut = useUpd ? updQ : parIn;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (capQ == 1'b0 && updQ == 1'b0));

  p_cap_load_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.doCapture && !strobe.doShift) |=> capQ == $past(parIn));

  p_shift_step_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.doShift |=> capQ == $past(serIn));

  p_upd_copy_r11: assert property (@(posedge clk) disable iff (rst)
    strobe.doUpdate |=> updQ == $past(capQ));

  p_upd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe.doUpdate |=> $stable(updQ));

  p_cap_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!strobe.doShift && !strobe.doCapture) |=> $stable(capQ));

endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
  import scan_chain_pkg::*;
(
  input  logic         shiftSel,
  input  logic         captureEn,
  input  logic         updateEn,
  input  logic [1:0]   mode,
  output scan_strobe_t strobe
);

  scan_mode_e modeSel;

  always_comb begin
    modeSel            = scan_mode_e'(mode);
    strobe             = '0;
    strobe.doShift     = captureEn & shiftSel;
    strobe.doCapture   = captureEn & ~shiftSel;
    strobe.doUpdate    = updateEn;
    unique case (modeSel)
      MODE_FUNC:  begin strobe.coreFromUpd = 1'b0; strobe.pinFromUpd = 1'b0; end
      MODE_EXT:   begin strobe.coreFromUpd = 1'b0; strobe.pinFromUpd = 1'b1; end
      MODE_INT:   begin strobe.coreFromUpd = 1'b1; strobe.pinFromUpd = 1'b0; end
      MODE_CLAMP: begin strobe.coreFromUpd = 1'b0; strobe.pinFromUpd = 1'b1; end
      default:    begin strobe.coreFromUpd = 1'b0; strobe.pinFromUpd = 1'b0; end
    endcase
  end

endmodule

// File: rtl/scan_chain_datapath.sv
module scan_chain_datapath
  import scan_chain_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  scan_strobe_t       strobe,
  input  logic               scanIn,
  output logic               scanOut,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic [NUM_OUT-1:0] pinOut
);

  localparam int LEN = NUM_IN + NUM_OUT;

  logic [LEN:0]   link;
  logic [LEN-1:0] parAll;
  logic [LEN-1:0] outAll;

  assign link[0] = scanIn;
  assign parAll  = {coreOut, pinIn};

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic useUpd;
    if (i < NUM_IN) begin : g_in_side
      assign useUpd = strobe.coreFromUpd;
    end else begin : g_out_side
      assign useUpd = strobe.pinFromUpd;
    end

    scan_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .useUpd (useUpd),
      .serIn  (link[i]),
      .serOut (link[i+1]),
      .parIn  (parAll[i]),
      .parOut (outAll[i])
    );
  end

  assign scanOut = link[LEN];
  assign coreIn  = outAll[NUM_IN-1:0];
  assign pinOut  = outAll[LEN-1:NUM_IN];

endmodule

// File: rtl/edge_scan_chain.sv
module edge_scan_chain
  import scan_chain_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shiftSel,
  input  logic               captureEn,
  input  logic               updateEn,
  input  logic [1:0]         mode,
  input  logic               scanIn,
  output logic               scanOut,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic [NUM_OUT-1:0] pinOut
);

  scan_strobe_t strobe;

  scan_chain_ctrl u_ctrl (
    .shiftSel  (shiftSel),
    .captureEn (captureEn),
    .updateEn  (updateEn),
    .mode      (mode),
    .strobe    (strobe)
  );

  scan_chain_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .scanIn  (scanIn),
    .scanOut (scanOut),
    .pinIn   (pinIn),
    .coreIn  (coreIn),
    .coreOut (coreOut),
    .pinOut  (pinOut)
  );

  p_func_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (coreIn == pinIn && pinOut == coreOut));

  p_ext_core_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> coreIn == pinIn);

  p_int_pin_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> pinOut == coreOut);

  p_clamp_core_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |-> coreIn == pinIn);

  p_pin_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode[0] && $past(mode[0]) && !$past(updateEn)) |-> $stable(pinOut));

endmodule

// File: tb/edge_scan_chain_test.sv
module edge_scan_chain_test;

  localparam int CLK_PERIOD = 10;
  localparam int NI  = 4;
  localparam int NO  = 4;
  localparam int LEN = NI + NO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftSel = 1'b0, captureEn = 1'b0, updateEn = 1'b0, scanIn = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [NI-1:0] pinIn = '0;
  logic [NO-1:0] coreOut = '0;
  logic          scanOut;
  logic [NI-1:0] coreIn;
  logic [NO-1:0] pinOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [LEN-1:0] capM = '0;
  logic [LEN-1:0] updM = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_scan_chain #(.NUM_IN(NI), .NUM_OUT(NO)) uut (
    .clk(clk), .rst(rst), .shiftSel(shiftSel), .captureEn(captureEn),
    .updateEn(updateEn), .mode(mode), .scanIn(scanIn), .scanOut(scanOut),
    .pinIn(pinIn), .coreIn(coreIn), .coreOut(coreOut), .pinOut(pinOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string serTag, input string outTag);
    logic [NI-1:0] expCore;
    logic [NO-1:0] expPin;
    string modeTag;
    expCore = (mode == 2'b10) ? updM[NI-1:0] : pinIn;
    expPin  = (mode == 2'b01 || mode == 2'b11) ? updM[LEN-1:NI] : coreOut;
    case (mode)
      2'b00: modeTag = "R6";
      2'b01: modeTag = "R7";
      2'b10: modeTag = "R8";
      default: modeTag = "R9";
    endcase
    check(serTag, 16'(scanOut), 16'(capM[LEN-1]));
    check((outTag == "") ? modeTag : outTag, 16'(coreIn), 16'(expCore));
    check((outTag == "") ? modeTag : outTag, 16'(pinOut), 16'(expPin));
  endtask

  task automatic step(input logic sh, input logic ce, input logic ue,
                      input logic [1:0] md, input logic si, input bit newPins,
                      input string serTag, input string outTag);
    logic [LEN-1:0] nextCap;
    @(negedge clk);
    shiftSel = sh; captureEn = ce; updateEn = ue; mode = md; scanIn = si;
    if (newPins) begin
      pinIn   = NI'($urandom);
      coreOut = NO'($urandom);
    end
    @(posedge clk);
    nextCap = capM;
    if (ce) nextCap = sh ? {capM[LEN-2:0], si} : {coreOut, pinIn};
    if (ue) updM = capM;
    capM = nextCap;
    #1;
    compare(serTag, outTag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    mode = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    capM = '0; updM = '0;
    // R1: all stages zero after reset, seen through test-driven outputs
    check("R1", 16'(pinOut), 16'h0);
    check("R1", 16'(scanOut), 16'h0);
    mode = 2'b10; #1;
    check("R1", 16'(coreIn), 16'h0);
    rst = 1'b0;

    // R2: parallel capture, then shift out to observe
    step(0, 1, 0, 2'b00, 0, 1, "R2", "");
    for (int i = 0; i < LEN; i++) step(1, 1, 0, 2'b01, 1'(i % 3 == 0), 1, "R3", "R5");
    // R4: update, then each mode on held values
    step(0, 0, 1, 2'b01, 0, 1, "R10", "R4");
    step(0, 0, 0, 2'b01, 0, 1, "R10", "R7");
    step(0, 0, 0, 2'b10, 0, 1, "R10", "R8");
    step(0, 0, 0, 2'b11, 0, 1, "R10", "R9");
    step(0, 0, 0, 2'b00, 0, 1, "R10", "R6");
    // R10: shiftSel alone does nothing
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2'b10, 1, 1, "R10", "");
    // R5: shifting under external/internal test keeps outputs fixed
    for (int i = 0; i < LEN; i++) step(1, 1, 0, 2'(1 + (i % 2)), 1'(i % 2), 1, "R3", "R5");
    // R11: capture or shift coinciding with update
    step(0, 1, 1, 2'b10, 0, 1, "R11", "R11");
    step(1, 1, 1, 2'b01, 1, 1, "R11", "R11");
    step(0, 0, 1, 2'b11, 0, 1, "R10", "R4");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] r;
      r = 5'($urandom);
      step(r[0], r[1], r[2] & r[3], 2'($urandom), r[4], 1, "R3", "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule